// File: doc/BRIEF.md
# Multiplier-Free Complex Frequency Shifter

This block moves a complex baseband or IF stream in frequency. Every accepted I/Q sample is turned through an angle read from an internal phase accumulator, and the turn is made by a pipelined chain of shift-and-add micro-rotations, so the datapath uses no multiplier. Because the input sample is itself the vector being rotated, the block needs no separate sine/cosine source and no complex multiplier behind one.

A user supplies a signed frequency word. After each accepted sample the phase register grows by that word, modulo one full turn. A positive word moves the spectrum up and a negative word moves it down. The same block therefore serves digital down-conversion from an IF and the correction of a carrier frequency offset of either sign. Before the micro-rotations, a coarse step of 0, +90, 180 or -90 degrees brings the leftover angle into a window of plus or minus one eighth of a turn.

Samples flow at one per clock with no stalls. A valid flag travels beside the data, so gaps in the input stream appear as gaps at the output after a fixed latency.

Top module: `cordic_ddc_rotator`

## Requirements
- R1: For an accepted sample (I, Q) with applied phase P, the output equals G·(I·cos θ − Q·sin θ) and G·(I·sin θ + Q·cos θ) within ±8 LSB. Here θ = 2π·P / 2^PW and G = K/4, where K ≈ 1.64676 is the micro-rotation gain for ITER stages. The internal paths are DW+2 bits wide, and the output keeps their top DW bits.
- R2: The first sample accepted after reset uses phase 0. Each accepted sample then adds freq_word to the phase, modulo 2^PW, and the sum is used by the next accepted sample.
- R3: In a cycle where in_valid is low, the phase is left unchanged and freq_word and the sample inputs have no effect.
- R4: out_valid is high exactly ITER+1 clock edges after each edge at which in_valid was high, and it is low at all other times.
- R5: Samples accepted on consecutive clocks come out on consecutive clocks, one per clock, with no bubbles.
- R6: A negative freq_word, taken as two's complement, makes the phase decrease, so the stream is rotated backward.
- R7: Phases in all four quadrants, including exactly 90, 180 and 270 degrees, are handled. Full-scale inputs, −2^(DW−1) included, never wrap the internal paths.
- R8: A synchronous active-high reset clears out_valid, discards the samples in flight and returns the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier; the phase advances only when high |
| in_i | input | DW | In-phase input, signed |
| in_q | input | DW | Quadrature input, signed |
| freq_word | input | PW | Phase increment per accepted sample, two's complement |
| out_valid | output | 1 | Marks a rotated output sample |
| out_i | output | DW | Rotated in-phase output, signed, gain K/4 |
| out_q | output | DW | Rotated quadrature output, signed, gain K/4 |

## Verification
Embedded properties check the following on every cycle:
- The phase holds while the input is idle, and grows by exactly the frequency word on each accepted sample.
- The leftover angle after the quadrant step stays inside ±1/8 turn.
- No micro-rotation stage comes near its word-width limit.
- The final leftover angle has converged to a few table steps.

Only the bench's scenarios can show the numerical result of the rotation against true trigonometry, the exact output latency and gap pattern, the behaviour of a negative word, and the flushing of samples in flight by a mid-stream reset.

// File: rtl/cordic_ddc_pkg.sv
package cordic_ddc_pkg;

  // Coarse pre-rotation chosen from the top two bits of the rounded phase.
  typedef enum logic [1:0] {
    QUAD_0   = 2'd0,
    QUAD_P90 = 2'd1,
    QUAD_180 = 2'd2,
    QUAD_M90 = 2'd3
  } quad_e;

  localparam real TURN_RAD = 6.283185307179586;

  // Angle of arctan(2^-k), in units where 2^aw is one full turn.
  function automatic int atan_units(input int k, input int aw);
    real r;
    r = $atan(1.0 / (2.0 ** k)) / TURN_RAD * (2.0 ** aw);
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/cddc_phase_acc.sv
module cddc_phase_acc #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (adv) begin
      phase <= phase + step;
    end
  end

  // R3: no accepted sample, no phase movement
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase));

  // R2: each accepted sample moves the phase by the word it arrived with
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    adv |=> phase == $past(phase) + $past(step));

endmodule

// File: rtl/cddc_quadrant.sv
module cddc_quadrant
  import cordic_ddc_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 32,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  input  logic [PW-1:0]        phase,
  output logic                 v_out,
  output logic signed [DW+1:0] x_out,
  output logic signed [DW+1:0] y_out,
  output logic signed [AW-1:0] z_out
);

  localparam int XW = DW + 2;
  localparam logic [PW-1:0] QOFF = PW'(1) << (PW - 3);
  localparam logic signed [AW-1:0] ZLIM = AW'(1) <<< (AW - 3);

  quad_e                 quad;
  logic [PW-1:0]         resid;
  logic signed [XW-1:0]  xi, yi, x_n, y_n;
  logic signed [AW-1:0]  z_n;

  always_comb begin
    quad  = quad_e'(2'((phase + QOFF) >> (PW - 2)));
    resid = phase - {quad, {(PW-2){1'b0}}};
    z_n   = AW'($signed(resid) >>> (PW - AW));
    xi    = {{2{i_in[DW-1]}}, i_in};
    yi    = {{2{q_in[DW-1]}}, q_in};
    unique case (quad)
      QUAD_0:   begin x_n = xi;  y_n = yi;  end
      QUAD_P90: begin x_n = -yi; y_n = xi;  end
      QUAD_180: begin x_n = -xi; y_n = -yi; end
      default:  begin x_n = yi;  y_n = -xi; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    x_out <= x_n;
    y_out <= y_n;
    z_out <= z_n;
  end

  // R1: leftover angle after the coarse step lies in [-1/8, +1/8) turn
  a_r1_residual_in_range: assert property (@(posedge clk) disable iff (rst)
    v_out |-> (z_out >= -ZLIM) && (z_out < ZLIM));

endmodule

// File: rtl/cddc_iter_stage.sv
module cddc_iter_stage
  import cordic_ddc_pkg::*;
#(
  parameter int XW    = 18,
  parameter int AW    = 24,
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [XW-1:0] x_in,
  input  logic signed [XW-1:0] y_in,
  input  logic signed [AW-1:0] z_in,
  output logic                 v_out,
  output logic signed [XW-1:0] x_out,
  output logic signed [XW-1:0] y_out,
  output logic signed [AW-1:0] z_out
);

  localparam logic signed [AW-1:0] STEP = AW'(atan_units(SHIFT, AW));
  localparam logic signed [XW-1:0] XLIM = XW'(3) <<< (XW - 3);

  logic                 turn_ccw;
  logic signed [XW-1:0] xs, ys, x_n, y_n;
  logic signed [AW-1:0] z_n;

  always_comb begin
    turn_ccw = ~z_in[AW-1];
    xs  = x_in >>> SHIFT;
    ys  = y_in >>> SHIFT;
    x_n = turn_ccw ? (x_in - ys) : (x_in + ys);
    y_n = turn_ccw ? (y_in + xs) : (y_in - xs);
    z_n = turn_ccw ? (z_in - STEP) : (z_in + STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    x_out <= x_n;
    y_out <= y_n;
    z_out <= z_n;
  end

  // R7: growth stays well inside the widened path (no wrap)
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    v_out |-> (x_out < XLIM) && (x_out > -XLIM) && (y_out < XLIM) && (y_out > -XLIM));

endmodule

// File: rtl/cordic_ddc_rotator.sv
module cordic_ddc_rotator
  import cordic_ddc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PW   = 32,
  parameter int ITER = 16,
  parameter int AW   = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [PW-1:0]        freq_word,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int XW = DW + 2;
  localparam logic signed [AW-1:0] ZTOL = AW'(4 * atan_units(ITER - 1, AW) + ITER);

  logic [PW-1:0]        phase;
  logic                 vs [ITER+1];
  logic signed [XW-1:0] xs [ITER+1];
  logic signed [XW-1:0] ys [ITER+1];
  logic signed [AW-1:0] zs [ITER+1];

  cddc_phase_acc #(.PW(PW)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .adv   (in_valid),
    .step  (freq_word),
    .phase (phase)
  );

  cddc_quadrant #(.DW(DW), .PW(PW), .AW(AW)) u_quad (
    .clk   (clk),
    .rst   (rst),
    .v_in  (in_valid),
    .i_in  (in_i),
    .q_in  (in_q),
    .phase (phase),
    .v_out (vs[0]),
    .x_out (xs[0]),
    .y_out (ys[0]),
    .z_out (zs[0])
  );

  for (genvar g = 0; g < ITER; g++) begin : g_stage
    cddc_iter_stage #(.XW(XW), .AW(AW), .SHIFT(g)) u_iter (
      .clk   (clk),
      .rst   (rst),
      .v_in  (vs[g]),
      .x_in  (xs[g]),
      .y_in  (ys[g]),
      .z_in  (zs[g]),
      .v_out (vs[g+1]),
      .x_out (xs[g+1]),
      .y_out (ys[g+1]),
      .z_out (zs[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= vs[ITER];
  end

  always_ff @(posedge clk) begin
    out_i <= DW'(xs[ITER] >>> (XW - DW));
    out_q <= DW'(ys[ITER] >>> (XW - DW));
  end

  // R1: after the last micro-rotation only a tiny angle is left
  a_r1_converged: assert property (@(posedge clk) disable iff (rst)
    vs[ITER] |-> (zs[ITER] >= -ZTOL) && (zs[ITER] <= ZTOL));

endmodule

// File: tb/cordic_ddc_rotator_tb.sv
module cordic_ddc_rotator_tb;

  localparam int DW   = 16;
  localparam int PW   = 32;
  localparam int ITER = 16;
  localparam int AW   = 24;
  localparam real GAIN = 1.6467602581210656 / 4.0;
  localparam real TOL  = 8.0;
  localparam real TWO_PI = 6.283185307179586;

  typedef struct {
    int          due;
    int          i;
    int          q;
    logic [31:0] ph;
    string       tag;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic [PW-1:0]        freq_word = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_i, out_q;

  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] ref_ph = '0;
  exp_t        expq[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cordic_ddc_rotator #(.DW(DW), .PW(PW), .ITER(ITER), .AW(AW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .freq_word (freq_word),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk_bit(input string tag, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s cyc=%0d out_valid act=%b exp=%b", tag, cyc, act, expv);
    end
  endtask

  // Per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst) begin
      expq.delete();
    end else if (expq.size() > 0 && expq[0].due == cyc) begin
      exp_t e;
      real th, ex, ey, ax, ay;
      e  = expq.pop_front();
      th = TWO_PI * real'(e.ph) / (2.0 ** 32);
      ex = GAIN * (real'(e.i) * $cos(th) - real'(e.q) * $sin(th));
      ey = GAIN * (real'(e.i) * $sin(th) + real'(e.q) * $cos(th));
      ax = real'(int'(out_i));
      ay = real'(int'(out_q));
      chk_bit({e.tag, " R4 valid"}, out_valid, 1'b1);
      n_chk++;
      if ((ax - ex) > TOL || (ex - ax) > TOL || (ay - ey) > TOL || (ey - ay) > TOL) begin
        n_bad++;
        $display("FAIL %s R1 cyc=%0d in=(%0d,%0d) ph=%h act=(%0d,%0d) exp=(%0.1f,%0.1f)",
                 e.tag, cyc, e.i, e.q, e.ph, int'(out_i), int'(out_q), ex, ey);
      end
    end else begin
      chk_bit("R4 idle", out_valid, 1'b0);
    end
  end

  task automatic drive(input bit v, input int i, input int q, input logic [31:0] f,
                       input string tag);
    @(negedge clk);
    in_valid  = v;
    in_i      = DW'(i);
    in_q      = DW'(q);
    freq_word = f;
    if (v) begin
      exp_t e;
      e.due = cyc + ITER + 2;
      e.i = i; e.q = q; e.ph = ref_ph; e.tag = tag;
      expq.push_back(e);
      ref_ph = ref_ph + f;
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b0;
    ref_ph = '0;
  endtask

  task automatic idle(input int n, input logic [31:0] junk);
    for (int k = 0; k < n; k++) drive(1'b0, 12345, -2222, junk + 32'(k), "idle");
  endtask

  initial begin
    int a, b;
    do_reset(4);
    // R8: out_valid low right after reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_bit("R8 reset state", out_valid, 1'b0);
    end

    // R1: zero frequency, phase stays 0
    drive(1, 10000, 0, 32'h0, "R1 dc");
    drive(1, 0, 10000, 32'h0, "R1 dc");
    drive(1, -20000, 15000, 32'h0, "R1 dc");
    drive(1, 32767, -32768, 32'h0, "R1 dc");

    // R7 / R5: quarter-turn steps, full-scale, back to back
    drive(1, -32768, -32768, 32'h4000_0000, "R7 quad");
    drive(1, -32768, -32768, 32'h4000_0000, "R7 quad");
    drive(1, -32768, -32768, 32'h4000_0000, "R7 quad");
    drive(1, -32768, -32768, 32'h4000_0000, "R7 quad");
    drive(1, 32767, 32767, 32'h4000_0000, "R7 quad");
    drive(1, 32767, -32768, 32'h4000_0000, "R7 quad");
    drive(1, -32768, 32767, 32'h2000_0000, "R7 quad");
    drive(1, 32767, 0, 32'h2000_0000, "R7 quad");

    // R3: idle cycles with garbage word must not move the phase
    idle(6, 32'h1357_9BDF);
    drive(1, 20000, -5000, 32'h0123_4567, "R3 resume");
    drive(1, 20000, -5000, 32'h0123_4567, "R2 step");
    drive(1, 20000, -5000, 32'h0123_4567, "R2 step");

    // R6: negative frequency word, continuous stream (R5)
    for (int k = 0; k < 40; k++) begin
      a = (k * 7919) % 60000 - 30000;
      b = (k * 104729) % 60000 - 30000;
      drive(1, a, b, 32'hFEDC_BA99, "R6 neg");
    end

    // R8: reset while the pipeline is full, then phase restarts at 0
    for (int k = 0; k < 10; k++) drive(1, 9000, 9000, 32'h3000_0000, "R8 pre");
    do_reset(2);
    idle(ITER + 4, 32'hAAAA_5555);
    drive(1, 25000, -12000, 32'h1000_0000, "R8 phase0");
    drive(1, 25000, -12000, 32'h1000_0000, "R8 phase1");

    // R1 / R2 / R4: irregular valid pattern, wrapping phase
    for (int k = 0; k < 200; k++) begin
      a = int'($urandom_range(65535)) - 32768;
      b = int'($urandom_range(65535)) - 32768;
      drive(($urandom_range(3) != 0), a, b, 32'h0765_4321 + 32'(k * 977), "R1 mix");
    end
    idle(ITER + 6, 32'h0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog cyc=%0d act=running exp=finished", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule